// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave side of a four- or three-wire serial bus that reads and writes a small register file inside the chip. All of its logic runs on the chip clock. The bus pins are synchronized and their edges are detected before the frame engine uses them. Every access opens with a 16-bit header. The header carries a direction bit, a length code and a 13-bit start address. Data bytes follow the header, and the address counts down after each one.

Writes go into a shadow copy of the control registers. The values that the rest of the chip sees change all at once, only when the update location is written with its low bit set. A mode register chooses where read data leaves the block. In the default mode it leaves on the shared data pin, which the block turns around for the read phase. In the other mode it leaves on a separate output pin. A read-only location mirrors live status inputs.

A master may pause a short access by raising chip select between bytes. Raising chip select in the middle of a byte abandons the access.

Top module: `spi_regport`

## Requirements
- R1: An access begins when chip select falls. The first 16 bits taken on rising serial-clock edges form the header, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Length codes 00, 01 and 10 move 1, 2 and 3 data bytes. Once those bytes are done, any further clocks before chip select rises have no effect.
- R3: Length code 11 streams bytes until chip select rises.
- R4: After each data byte the register address decreases by one.
- R5: A written byte lands only in the shadow copy. The `ctrl_active` outputs keep their values until a byte with bit 0 set is written to address 0x232. That write copies every shadow register to its active copy in one step. Address 0x232 always reads as 0.
- R6: A read returns the shadow value of the addressed location, and 0 for an unmapped address. Bits go out most significant first. Each bit changes after a falling serial-clock edge, and the first bit appears after the falling edge that follows the 16th header bit.
- R7: Bit 0 of address 0x000 selects the read pin and takes effect as soon as it is written. With 0, read data is driven on `spi_sdio_out` with `spi_sdio_oe` high and `spi_sdo_oe` low. With 1, read data is driven on `spi_sdo` with `spi_sdo_oe` high and `spi_sdio_oe` low. Both enables are low outside the read data phase.
- R8: For length codes 00 to 10, a chip-select high at a byte boundary pauses the access. This includes the boundary between the two header bytes. The access resumes at the next byte when chip select falls again.
- R9: A chip-select rise in the middle of a byte discards that byte and ends the access.
- R10: Address 0x01F reads the live `status_in` value, and writes to it are ignored.
- R11: After reset, all shadow and active registers and the mode bit are 0, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdio_in | input | 1 | Receive side of the shared data pin |
| spi_sdio_out | output | 1 | Transmit side of the shared data pin |
| spi_sdio_oe | output | 1 | Drive enable for the shared data pin |
| spi_sdo | output | 1 | Separate read-data pin |
| spi_sdo_oe | output | 1 | Drive enable for the separate read pin |
| status_in | input | 8 | Live status word, readable at 0x01F |
| ctrl_active | output | 8*NUM_REGS | Active control registers; byte i belongs to address REG_BASE+i |

## Verification
The pins pass through two synchronizer flops and one edge register. As a result, a written byte reaches the shadow copy about four chip clocks after the eighth rising serial edge, and an update reaches `ctrl_active` one clock after that. A read bit settles about three chip clocks after its falling serial edge. The bench holds each serial-clock phase for six chip clocks and samples read data just before the next rising edge. It compares `ctrl_active` only after chip select has been high for at least twelve clocks, so every result has reached its port before it is looked at. A sweep over every start register and every short length computes the expected register image from an arithmetic data pattern.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int HDR_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_DONE
    } frame_state_e;

    typedef enum logic [1:0] {
        LEN_ONE    = 2'b00,
        LEN_TWO    = 2'b01,
        LEN_THREE  = 2'b10,
        LEN_STREAM = 2'b11
    } xfer_len_e;

    typedef struct packed {
        logic              is_read;
        xfer_len_e         len;
        logic [ADDR_W-1:0] addr;
    } header_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic may_pause(input xfer_len_e len);
        return len != LEN_STREAM;
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RESET_VAL;
                else     stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RESET_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge #(
    parameter int               WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_VAL;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_lvl,
    input  logic              csn_rise,
    input  logic              csn_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr_req,
    output logic              drive_en,
    output logic              out_bit
);
    localparam int CNT_W = $clog2(HDR_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] HDR_HALF  = CNT_W'(HDR_W / 2);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

    frame_state_e      state_q;
    logic              paused_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [HDR_W-2:0]  hdr_sh_q;
    logic [DATA_W-2:0] data_sh_q;
    logic [DATA_W-2:0] out_sh_q;
    header_t           cur_q;
    logic [1:0]        rem_q;
    xfer_len_e         early_len;

    assign early_len = xfer_len_e'(hdr_sh_q[DATA_W-2 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            paused_q  <= 1'b0;
            bit_cnt_q <= '0;
            hdr_sh_q  <= '0;
            data_sh_q <= '0;
            out_sh_q  <= '0;
            out_bit   <= 1'b0;
            cur_q     <= '0;
            rem_q     <= '0;
            wr_req    <= '0;
        end else begin
            wr_req.en <= 1'b0;
            if (csn_rise) begin
                unique case (state_q)
                    ST_HDR: begin
                        if (bit_cnt_q == HDR_HALF && may_pause(early_len)) paused_q <= 1'b1;
                        else state_q <= ST_IDLE;
                    end
                    ST_DATA: begin
                        if (bit_cnt_q == '0 && may_pause(cur_q.len)) paused_q <= 1'b1;
                        else state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end else if (csn_fall) begin
                if (paused_q) begin
                    paused_q <= 1'b0;
                end else begin
                    state_q   <= ST_HDR;
                    bit_cnt_q <= '0;
                end
            end else if (!csn_lvl) begin
                if (sclk_rise) begin
                    unique case (state_q)
                        ST_HDR: begin
                            hdr_sh_q <= {hdr_sh_q[HDR_W-3:0], sdi};
                            if (bit_cnt_q == HDR_LAST) begin
                                cur_q     <= header_t'({hdr_sh_q, sdi});
                                rem_q     <= hdr_sh_q[HDR_W-3 -: 2];
                                state_q   <= ST_DATA;
                                bit_cnt_q <= '0;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                        ST_DATA: begin
                            data_sh_q <= {data_sh_q[DATA_W-3:0], sdi};
                            if (bit_cnt_q == BYTE_LAST) begin
                                bit_cnt_q <= '0;
                                if (!cur_q.is_read) begin
                                    wr_req.en   <= 1'b1;
                                    wr_req.addr <= cur_q.addr;
                                    wr_req.data <= {data_sh_q, sdi};
                                end
                                cur_q.addr <= cur_q.addr - 1'b1;
                                if (cur_q.len != LEN_STREAM) begin
                                    if (rem_q == 2'd0) state_q <= ST_DONE;
                                    else rem_q <= rem_q - 1'b1;
                                end
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sclk_fall && state_q == ST_DATA && cur_q.is_read) begin
                    if (bit_cnt_q == '0) begin
                        out_bit  <= rd_data[DATA_W-1];
                        out_sh_q <= rd_data[DATA_W-2:0];
                    end else begin
                        out_bit  <= out_sh_q[DATA_W-2];
                        out_sh_q <= {out_sh_q[DATA_W-3:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_addr  = cur_q.addr;
    assign drive_en = (state_q == ST_DATA) && cur_q.is_read && !csn_lvl && !paused_q;

    // R5: a write request only follows a rising serial edge
    assert_write_after_clock_R5: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> $past(sclk_rise));

    // R8: a pause only starts on a byte boundary
    assert_pause_on_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(paused_q) |-> (bit_cnt_q == '0 || bit_cnt_q == HDR_HALF));

    // R9: a rise of chip select in the middle of a byte leaves no pause behind
    assert_mid_byte_ends_R9: assert property (@(posedge clk) disable iff (rst)
        (csn_rise && state_q == ST_DATA && bit_cnt_q != '0) |=> (state_q == ST_IDLE && !paused_q));
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
    import spi_regport_pkg::*;
#(
    parameter int                NUM_REGS    = 4,
    parameter logic [ADDR_W-1:0] REG_BASE    = 13'h010,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 13'h01F,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 13'h000,
    parameter logic [ADDR_W-1:0] UPDATE_ADDR = 13'h232
) (
    input  logic                             clk,
    input  logic                             rst,
    input  wr_req_t                          wr_req,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [DATA_W-1:0]                status_i,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             mode_sep_o,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  active_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] active_q;
    logic [NUM_REGS-1:0]             rd_hit;
    logic                            upd_fire;
    logic                            mode_q;

    assign upd_fire = wr_req.en && wr_req.addr == UPDATE_ADDR && wr_req.data[0];

    always_ff @(posedge clk) begin
        if (rst)                                        mode_q <= 1'b0;
        else if (wr_req.en && wr_req.addr == MODE_ADDR) mode_q <= wr_req.data[0];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst)                                      shadow_q[i] <= '0;
            else if (wr_req.en && wr_req.addr == MY_ADDR) shadow_q[i] <= wr_req.data;
        end

        always_ff @(posedge clk) begin
            if (rst)           active_q[i] <= '0;
            else if (upd_fire) active_q[i] <= shadow_q[i];
        end

        assign rd_hit[i] = (rd_addr == MY_ADDR);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == MODE_ADDR)        rd_data = {{(DATA_W-1){1'b0}}, mode_q};
        else if (rd_addr == STATUS_ADDR) rd_data = status_i;
        else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (rd_hit[i]) rd_data = shadow_q[i];
        end
    end

    assign mode_sep_o = mode_q;
    assign active_o   = active_q;

    // R5: an update copies the whole shadow image
    assert_update_copies_R5: assert property (@(posedge clk) disable iff (rst)
        upd_fire |=> (active_q == $past(shadow_q)));

    // R5: without an update the active image holds
    assert_active_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !upd_fire |=> $stable(active_q));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int                NUM_REGS    = 4,
    parameter logic [ADDR_W-1:0] REG_BASE    = 13'h010,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 13'h01F,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 13'h000,
    parameter logic [ADDR_W-1:0] UPDATE_ADDR = 13'h232,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       spi_csn,
    input  logic                       spi_sclk,
    input  logic                       spi_sdio_in,
    output logic                       spi_sdio_out,
    output logic                       spi_sdio_oe,
    output logic                       spi_sdo,
    output logic                       spi_sdo_oe,
    input  logic [DATA_W-1:0]          status_in,
    output logic [NUM_REGS*DATA_W-1:0] ctrl_active
);
    logic [2:0]               pins_lvl;
    logic [1:0]               edge_rise;
    logic [1:0]               edge_fall;
    logic [ADDR_W-1:0]        rd_addr;
    logic [DATA_W-1:0]        rd_data;
    wr_req_t                  wr_req;
    logic                     drive_en;
    logic                     out_bit;
    logic                     mode_sep;
    logic [NUM_REGS-1:0][DATA_W-1:0] active;

    spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i ({spi_csn, spi_sclk, spi_sdio_in}),
        .level_o (pins_lvl)
    );

    spi_regport_edge #(.WIDTH(2), .RESET_VAL(2'b10)) edge_i (
        .clk     (clk),
        .rst     (rst),
        .level_i (pins_lvl[2:1]),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    spi_regport_frame frame_i (
        .clk       (clk),
        .rst       (rst),
        .csn_lvl   (pins_lvl[2]),
        .csn_rise  (edge_rise[1]),
        .csn_fall  (edge_fall[1]),
        .sclk_rise (edge_rise[0]),
        .sclk_fall (edge_fall[0]),
        .sdi       (pins_lvl[0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .drive_en  (drive_en),
        .out_bit   (out_bit)
    );

    spi_regport_regs #(
        .NUM_REGS    (NUM_REGS),
        .REG_BASE    (REG_BASE),
        .STATUS_ADDR (STATUS_ADDR),
        .MODE_ADDR   (MODE_ADDR),
        .UPDATE_ADDR (UPDATE_ADDR)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_addr    (rd_addr),
        .status_i   (status_in),
        .rd_data    (rd_data),
        .mode_sep_o (mode_sep),
        .active_o   (active)
    );

    assign spi_sdio_out = out_bit;
    assign spi_sdo      = out_bit;
    assign spi_sdio_oe  = drive_en && !mode_sep;
    assign spi_sdo_oe   = drive_en && mode_sep;
    assign ctrl_active  = active;

    // R7: never both pins driven
    assert_single_driver_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({spi_sdio_oe, spi_sdo_oe}));

    // R7: nothing driven while deselected
    assert_quiet_deselected_R7: assert property (@(posedge clk) disable iff (rst)
        pins_lvl[2] |-> !(spi_sdio_oe || spi_sdo_oe));
endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NREG       = 4;
    localparam logic [12:0] BASE = 13'h010;
    localparam logic [12:0] STAT = 13'h01F;
    localparam logic [12:0] MODE = 13'h000;
    localparam logic [12:0] UPD  = 13'h232;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdi_drv = 1'b0;
    logic [7:0] status = 8'h00;
    logic sdio_out, sdio_oe, sdo, sdo_oe, sdio_pin;
    logic [NREG*8-1:0] ctrl_active;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_shadow [NREG];
    logic [7:0] m_active [NREG];
    logic m_mode = 1'b0;

    assign sdio_pin = sdio_oe ? sdio_out : sdi_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport dut_i (
        .clk (clk), .rst (rst),
        .spi_csn (csn), .spi_sclk (sclk), .spi_sdio_in (sdio_pin),
        .spi_sdio_out (sdio_out), .spi_sdio_oe (sdio_oe),
        .spi_sdo (sdo), .spi_sdo_oe (sdo_oe),
        .status_in (status), .ctrl_active (ctrl_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic bit_io(input logic b, output logic q, inout logic oe_ok);
        sdi_drv = b;
        wait_clk(HALF);
        q = m_mode ? sdo : sdio_out;
        oe_ok &= m_mode ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        logic q;
        logic ok;
        for (int i = n - 1; i >= 0; i--) bit_io(w[i], q, ok);
    endtask

    task automatic recv_byte(output logic [7:0] d, inout logic oe_ok);
        logic q;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b0, q, oe_ok);
            d[i] = q;
        end
    endtask

    task automatic mdl_write(input logic [12:0] a, input logic [7:0] d);
        if (a == MODE) m_mode = d[0];
        else if (a >= BASE && a < BASE + NREG) m_shadow[a - BASE] = d;
        else if (a == UPD && d[0]) begin
            for (int i = 0; i < NREG; i++) m_active[i] = m_shadow[i];
        end
    endtask

    function automatic logic [7:0] mdl_read(input logic [12:0] a);
        if (a == MODE) return {7'b0, m_mode};
        if (a == STAT) return status;
        if (a >= BASE && a < BASE + NREG) return m_shadow[a - BASE];
        return 8'h00;
    endfunction

    function automatic logic [31:0] exp_active();
        logic [31:0] v = '0;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_active[i];
        return v;
    endfunction

    // writes n bytes, taken from the top of d; bytes beyond the length are sent but must be ignored
    task automatic do_write(input logic [12:0] a, input logic [1:0] len, input int n, input logic [31:0] d);
        int lim;
        sel();
        send_bits({1'b0, len, a}, 16);
        for (int i = 0; i < n; i++) send_bits({8'h00, d[31 - 8*i -: 8]}, 8);
        desel();
        lim = (len == 2'b11) ? n : ((n < int'(len) + 1) ? n : int'(len) + 1);
        for (int i = 0; i < lim; i++) mdl_write(a - 13'(i), d[31 - 8*i -: 8]);
    endtask

    task automatic check_read(input string tag, input logic [12:0] a, input logic [1:0] len, input int n);
        logic [31:0] got = '0;
        logic [31:0] exp = '0;
        logic [7:0] b;
        logic oe_ok = 1'b1;
        sel();
        send_bits({1'b1, len, a}, 16);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, oe_ok);
            got = {got[23:0], b};
            exp = {exp[23:0], mdl_read(a - 13'(i))};
        end
        desel();
        chk(tag, got, exp);
        chk({tag, " enable"}, {31'b0, oe_ok}, 32'd1);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_shadow[i] = 8'h00;
            m_active[i] = 8'h00;
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R11: reset state
        chk("R11 active after reset", ctrl_active, 32'h0);
        chk("R11 enables after reset", {30'b0, sdio_oe, sdo_oe}, 32'h0);

        // R1 R5 R6: single write stays in shadow, reads back
        do_write(BASE, 2'b00, 1, 32'hA500_0000);
        chk("R5 active unchanged before update", ctrl_active, 32'h0);
        check_read("R1 R6 read shadow", BASE, 2'b00, 1);

        // R5: update copies, update address reads zero
        do_write(UPD, 2'b00, 1, 32'h0100_0000);
        chk("R5 active after update", ctrl_active, exp_active());
        check_read("R5 update reads zero", UPD, 2'b00, 1);

        // R2 R4: three-byte write, a fourth byte in the same select is ignored
        do_write(BASE + 13'd3, 2'b10, 4, 32'h1122_3344);
        check_read("R2 R4 length three then ignore", BASE + 13'd3, 2'b11, 4);

        // R3: streaming write and read over all registers
        do_write(BASE + 13'd3, 2'b11, 4, 32'hC0DE_F00D);
        check_read("R3 streaming read", BASE + 13'd3, 2'b11, 4);
        do_write(UPD, 2'b00, 1, 32'h0300_0000);
        chk("R3 R5 active after stream", ctrl_active, exp_active());

        // R8: pause between header bytes and between data bytes
        sel();
        send_bits({8'h00, 1'b0, 2'b01, 5'h00}, 8);
        desel();
        sel();
        send_bits({8'h00, 8'h12}, 8);
        send_bits({8'h00, 8'h6B}, 8);
        desel();
        sel();
        send_bits({8'h00, 8'h9E}, 8);
        desel();
        mdl_write(BASE + 13'd2, 8'h6B);
        mdl_write(BASE + 13'd1, 8'h9E);
        check_read("R8 paused write", BASE + 13'd2, 2'b01, 2);

        // R8: pause inside a two-byte read
        begin
            logic [7:0] b0, b1;
            logic ok = 1'b1;
            sel();
            send_bits({1'b1, 2'b01, BASE + 13'd2}, 16);
            recv_byte(b0, ok);
            desel();
            sel();
            recv_byte(b1, ok);
            desel();
            chk("R8 paused read", {16'h0, b0, b1}, {16'h0, mdl_read(BASE + 13'd2), mdl_read(BASE + 13'd1)});
            chk("R8 paused read enable", {31'b0, ok}, 32'd1);
        end

        // R9: chip select rises mid-byte, byte discarded
        sel();
        send_bits({1'b0, 2'b00, BASE}, 16);
        send_bits(16'h000F, 4);
        desel();
        check_read("R9 mid-byte abort", BASE, 2'b00, 1);

        // R10: live status, writes ignored
        status = 8'h3C;
        check_read("R10 status live A", STAT, 2'b00, 1);
        status = 8'hC3;
        do_write(STAT, 2'b00, 1, 32'h5500_0000);
        check_read("R10 status after write", STAT, 2'b00, 1);

        // R6: unmapped address
        check_read("R6 unmapped zero", 13'h100, 2'b00, 1);

        // R7: separate read pin
        do_write(MODE, 2'b00, 1, 32'h0100_0000);
        check_read("R7 read on separate pin", BASE + 13'd3, 2'b01, 2);
        check_read("R7 mode readback", MODE, 2'b00, 1);
        do_write(MODE, 2'b00, 1, 32'h0000_0000);
        check_read("R7 back to shared pin", BASE, 2'b00, 1);
        chk("R7 enables idle", {30'b0, sdio_oe, sdo_oe}, 32'h0);

        // R2 R4 R5: sweep every start register and every short length
        for (int s = 0; s < NREG; s++) begin
            for (int l = 0; l < 3; l++) begin
                logic [31:0] d = '0;
                logic [12:0] a = BASE + 13'(s);
                for (int i = 0; i < 4; i++) d[31 - 8*i -: 8] = 8'(s*37 + l*11 + i*5 + 1);
                do_write(a, 2'(l), l + 1, d);
                check_read("R2 R4 sweep read", a, 2'(l), l + 1);
                do_write(UPD, 2'b00, 1, 32'h0100_0000);
                chk("R5 sweep active", ctrl_active, exp_active());
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule